// File: doc/BRIEF.md
# Toggle-Signalled Microstore Loader

This block listens to a 16-bit control register that a slow host rewrites one word at a time. The host gives no strobe. It announces every new word by inverting the register's most significant bit, and it keeps the lower 15 bits steady for a limited time afterwards. The block passes the register through a synchronizer and notices each inversion of the top bit. After a configurable number of settle cycles it captures the 15-bit payload, which always falls well inside the host's hold window.

Captured words form a transfer with a fixed order. The first word is the starting microstore address and the second is the number of hunks. Next come eight half-instructions per hunk, each sent as two words. Last comes a two-word checksum. The block holds each left half until the matching right half arrives. It then writes the joined 34-bit instruction, with its breakpoint bit, to a microstore write port and advances the address. At the end it compares its own running sum against the received checksum and shows the outcome on a 4-bit status output. Code 1 is the acknowledge.

Top module: `tcr_receiver`

## Requirements
- R1: A word is accepted only when register bit 15 differs from its last-seen value. A reset sets the last-seen value to 1, so a word whose bit 15 stays at 1 after reset, or any change to bits 14..0 without a change of bit 15, is ignored.
- R2: The payload (bits 14..0) is captured SETTLE_CYC cycles after the toggle is detected, which is always fewer than WINDOW_CYC cycles. Changes to the payload driven four cycles or more after the toggle, without a new toggle, do not alter the captured word.
- R3: A transfer consists of an address word (bits ADDR_W-1..0) and a count word (bits CNT_W-1..0, in hunks). These are followed by 8 half-instructions per hunk and then by the checksum.
- R4: A half-instruction takes two words. The first word carries data bits 7..0 in bits 7..0. The second word carries data bits 15..8 in bits 7..0, data bit 16 in bit 8, the half select in bit 9 (0 = left, 1 = right) and the breakpoint flag in bit 10. A right half that follows a pending left half writes data {left[16:0], right[16:0]}. The breakpoint output is the OR of the two halves' flags.
- R5: The first write of a transfer goes to the address word's value, and each later write goes to the previous write address plus 1.
- R6: The write enable is a single-cycle pulse. It is high in clock cycle SYNC_STAGES+SETTLE_CYC+2 after the completing word is driven, counting the first rising edge as 1.
- R7: The checksum is sent as a low-byte word (bits 7..0) followed by a high-byte word (bits 7..0, with bit 14 as the good mark). If the good mark is 1, the value equals the sum modulo 2^16 of all half-instruction data, and no order error occurred, the status becomes 1 (acknowledge).
- R8: A right half with no pending left half writes nothing and sets the status to 8. The status stays 8 through the end of that transfer, so no acknowledge is given.
- R9: A checksum that differs from the sum, or a good mark of 0, sets the status to 9.
- R10: A count of 0 moves directly from the count word to the checksum words with no writes. A checksum of 0 then acknowledges.
- R11: After reset the status is 0 and the write enable is low. An address word sets the status to 2 (busy).
- R12: A left half that arrives while another left half is pending replaces it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpreg_i | input | 16 | Raw control register from the host |
| im_we_o | output | 1 | Microstore write enable pulse |
| im_addr_o | output | ADDR_W | Microstore write address |
| im_data_o | output | 34 | Joined microinstruction {left, right} |
| im_bp_o | output | 1 | Breakpoint bit written with the instruction |
| status_o | output | 4 | 0 idle, 1 acknowledge, 2 busy, 8 order error, 9 checksum error |

## Verification
Every word passes through SYNC_STAGES synchronizer flops, one edge-detect register, SETTLE_CYC settle cycles and one assembler register. Its write pulse and its status update therefore appear in cycle SYNC_STAGES+SETTLE_CYC+2 after the word is driven, which is cycle 6 with the default settings. One directed test samples the write enable on the falling edges of cycles 5, 6 and 7 to pin down that exact cycle. All other checks send words twelve cycles apart and read results only after that gap, so every result is already due when it is sampled. A falling-edge monitor logs each write pulse exactly once.

// File: rtl/tcr_pkg.sv
package tcr_pkg;
   localparam int WORD_W    = 16;
   localparam int PAY_W     = 15;
   localparam int HALF_W    = 17;
   localparam int INSN_W    = 2 * HALF_W;
   localparam int HALVES_PER_HUNK_LG = 3;
   localparam int XBIT_POS  = 8;
   localparam int SEL_POS   = 9;
   localparam int BRK_POS   = 10;
   localparam int GOOD_POS  = 14;

   typedef enum logic [3:0] {
      ST_IDLE      = 4'd0,
      ST_ACK       = 4'd1,
      ST_BUSY      = 4'd2,
      ST_ERR_ORDER = 4'd8,
      ST_ERR_SUM   = 4'd9
   } tcr_status_e;

   typedef enum logic [2:0] {
      PH_ADDR,
      PH_COUNT,
      PH_DLO,
      PH_DHI,
      PH_SLO,
      PH_SHI
   } tcr_phase_e;
endpackage

// File: rtl/tcr_edge_capture.sv
module tcr_edge_capture
   import tcr_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int SETTLE_CYC  = 2,
   parameter int WINDOW_CYC  = 2500
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WORD_W-1:0] reg_i,
   output logic             word_vld_o,
   output logic [PAY_W-1:0] word_o
);
   localparam int CNT_W = $clog2(SETTLE_CYC + 1);
   localparam int AGE_W = $clog2(WINDOW_CYC + 1);
   localparam int LAST  = SYNC_STAGES - 1;

   generate
      if (SETTLE_CYC < 1 || SETTLE_CYC >= WINDOW_CYC) begin : g_bad_settle
         $error("tcr_edge_capture: SETTLE_CYC must be in 1..WINDOW_CYC-1");
      end
   endgenerate

   logic [WORD_W-1:0] sync_q [SYNC_STAGES];

   generate
      for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
         if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (rst) sync_q[g] <= WORD_W'(1) << (WORD_W - 1);
               else     sync_q[g] <= reg_i;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (rst) sync_q[g] <= WORD_W'(1) << (WORD_W - 1);
               else     sync_q[g] <= sync_q[g-1];
            end
         end
      end
   endgenerate

   logic             top_s;
   logic             last_top;
   logic [CNT_W-1:0] settle_cnt;

   assign top_s = sync_q[LAST][WORD_W-1];

   always_ff @(posedge clk) begin
      if (rst) begin
         last_top   <= 1'b1;
         settle_cnt <= '0;
         word_vld_o <= 1'b0;
         word_o     <= '0;
      end else begin
         word_vld_o <= 1'b0;
         if (top_s != last_top) begin
            last_top   <= top_s;
            settle_cnt <= CNT_W'(SETTLE_CYC);
         end else if (settle_cnt != '0) begin
            settle_cnt <= settle_cnt - 1'b1;
            if (settle_cnt == CNT_W'(1)) begin
               word_vld_o <= 1'b1;
               word_o     <= sync_q[LAST][PAY_W-1:0];
            end
         end
      end
   end

   // cycles since the last detected toggle, saturating, for the window check
   logic [AGE_W-1:0] age_q;
   always_ff @(posedge clk) begin
      if (rst)                         age_q <= '0;
      else if (top_s != last_top)      age_q <= '0;
      else if (age_q != AGE_W'(WINDOW_CYC)) age_q <= age_q + 1'b1;
   end

   AST_SAMPLE_WINDOW: assert property (@(posedge clk) disable iff (rst)
      word_vld_o |-> (age_q == AGE_W'(SETTLE_CYC)) && (age_q < AGE_W'(WINDOW_CYC))); // R2
endmodule

// File: rtl/tcr_csum.sv
module tcr_csum
   import tcr_pkg::*;
(
   input  logic              clk,
   input  logic              rst,
   input  logic              clr_i,
   input  logic              add_i,
   input  logic [HALF_W-1:0] val_i,
   output logic [15:0]       sum_o
);
   always_ff @(posedge clk) begin
      if (rst || clr_i) sum_o <= '0;
      else if (add_i)   sum_o <= sum_o + val_i[15:0];
   end
endmodule

// File: rtl/tcr_assembler.sv
module tcr_assembler
   import tcr_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int CNT_W  = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              word_vld_i,
   input  logic [PAY_W-1:0]  word_i,
   input  logic [15:0]       csum_i,
   output logic              csum_clr_o,
   output logic              csum_add_o,
   output logic [HALF_W-1:0] csum_val_o,
   output logic              we_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [INSN_W-1:0] data_o,
   output logic              bp_o,
   output logic [3:0]        status_o
);
   localparam int HC_W = CNT_W + HALVES_PER_HUNK_LG;

   tcr_phase_e        phase;
   tcr_status_e       status_q;
   logic [ADDR_W-1:0] cur_addr;
   logic [HC_W-1:0]   halves_left;
   logic [7:0]        lo_byte;
   logic [7:0]        sum_lo;
   logic [HALF_W-1:0] left_q;
   logic              left_bp;
   logic              left_vld;
   logic              order_err;
   logic [HALF_W-1:0] half;

   assign half       = {word_i[XBIT_POS], word_i[7:0], lo_byte};
   assign csum_clr_o = word_vld_i && (phase == PH_ADDR);
   assign csum_add_o = word_vld_i && (phase == PH_DHI);
   assign csum_val_o = half;
   assign status_o   = status_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         phase       <= PH_ADDR;
         status_q    <= ST_IDLE;
         cur_addr    <= '0;
         halves_left <= '0;
         lo_byte     <= '0;
         sum_lo      <= '0;
         left_q      <= '0;
         left_bp     <= 1'b0;
         left_vld    <= 1'b0;
         order_err   <= 1'b0;
         we_o        <= 1'b0;
         addr_o      <= '0;
         data_o      <= '0;
         bp_o        <= 1'b0;
      end else begin
         we_o <= 1'b0;
         if (word_vld_i) begin
            case (phase)
               PH_ADDR: begin
                  cur_addr  <= word_i[ADDR_W-1:0];
                  status_q  <= ST_BUSY;
                  order_err <= 1'b0;
                  left_vld  <= 1'b0;
                  phase     <= PH_COUNT;
               end
               PH_COUNT: begin
                  halves_left <= {word_i[CNT_W-1:0], {HALVES_PER_HUNK_LG{1'b0}}};
                  phase <= (word_i[CNT_W-1:0] == '0) ? PH_SLO : PH_DLO;
               end
               PH_DLO: begin
                  lo_byte <= word_i[7:0];
                  phase   <= PH_DHI;
               end
               PH_DHI: begin
                  if (!word_i[SEL_POS]) begin
                     left_q   <= half;
                     left_bp  <= word_i[BRK_POS];
                     left_vld <= 1'b1;
                  end else if (left_vld) begin
                     we_o     <= 1'b1;
                     addr_o   <= cur_addr;
                     data_o   <= {left_q, half};
                     bp_o     <= left_bp | word_i[BRK_POS];
                     cur_addr <= cur_addr + 1'b1;
                     left_vld <= 1'b0;
                  end else begin
                     order_err <= 1'b1;
                     status_q  <= ST_ERR_ORDER;
                  end
                  halves_left <= halves_left - 1'b1;
                  phase <= (halves_left == HC_W'(1)) ? PH_SLO : PH_DLO;
               end
               PH_SLO: begin
                  sum_lo <= word_i[7:0];
                  phase  <= PH_SHI;
               end
               PH_SHI: begin
                  phase <= PH_ADDR;
                  if (order_err)
                     status_q <= ST_ERR_ORDER;
                  else if (word_i[GOOD_POS] && ({word_i[7:0], sum_lo} == csum_i))
                     status_q <= ST_ACK;
                  else
                     status_q <= ST_ERR_SUM;
               end
               default: phase <= PH_ADDR;
            endcase
         end
      end
   end

   AST_WRITE_NEEDS_LEFT: assert property (@(posedge clk) disable iff (rst)
      we_o |-> $past(left_vld)); // R8
   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
      we_o |-> (cur_addr == ADDR_W'(addr_o + 1'b1))); // R5
   AST_ACK_CLEAN: assert property (@(posedge clk) disable iff (rst)
      (status_q == ST_ACK) |-> !order_err); // R8
   AST_ACK_AT_END: assert property (@(posedge clk) disable iff (rst)
      $rose(status_q == ST_ACK) |-> (phase == PH_ADDR)); // R7
endmodule

// File: rtl/tcr_receiver.sv
module tcr_receiver
   import tcr_pkg::*;
#(
   parameter int ADDR_W      = 12,
   parameter int CNT_W       = 8,
   parameter int SYNC_STAGES = 2,
   parameter int SETTLE_CYC  = 2,
   parameter int WINDOW_CYC  = 2500
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [15:0]       cpreg_i,
   output logic              im_we_o,
   output logic [ADDR_W-1:0] im_addr_o,
   output logic [33:0]       im_data_o,
   output logic              im_bp_o,
   output logic [3:0]        status_o
);
   generate
      if (ADDR_W < 1 || ADDR_W > PAY_W) begin : g_bad_addr
         $error("tcr_receiver: ADDR_W must fit in the payload");
      end
      if (CNT_W < 1 || CNT_W > 12) begin : g_bad_cnt
         $error("tcr_receiver: CNT_W must be in 1..12");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("tcr_receiver: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic              word_vld;
   logic [PAY_W-1:0]  word;
   logic              csum_clr;
   logic              csum_add;
   logic [HALF_W-1:0] csum_val;
   logic [15:0]       csum;

   tcr_edge_capture #(
      .SYNC_STAGES (SYNC_STAGES),
      .SETTLE_CYC  (SETTLE_CYC),
      .WINDOW_CYC  (WINDOW_CYC)
   ) u_edge (
      .clk        (clk),
      .rst        (rst),
      .reg_i      (cpreg_i),
      .word_vld_o (word_vld),
      .word_o     (word)
   );

   tcr_csum u_csum (
      .clk   (clk),
      .rst   (rst),
      .clr_i (csum_clr),
      .add_i (csum_add),
      .val_i (csum_val),
      .sum_o (csum)
   );

   tcr_assembler #(
      .ADDR_W (ADDR_W),
      .CNT_W  (CNT_W)
   ) u_asm (
      .clk        (clk),
      .rst        (rst),
      .word_vld_i (word_vld),
      .word_i     (word),
      .csum_i     (csum),
      .csum_clr_o (csum_clr),
      .csum_add_o (csum_add),
      .csum_val_o (csum_val),
      .we_o       (im_we_o),
      .addr_o     (im_addr_o),
      .data_o     (im_data_o),
      .bp_o       (im_bp_o),
      .status_o   (status_o)
   );
endmodule

// File: tb/sim_tcr_receiver.sv
module sim_tcr_receiver;
   localparam int AW  = 12;
   localparam int GAP = 12;
   // fields: bit18 breakpoint, bit17 right-half select, bits16..0 data
   localparam logic [18:0] VEC [8] = '{
      19'h12345, 19'h2ABCD, 19'h5FFFF, 19'h20001,
      19'h08000, 19'h70F0F, 19'h00000, 19'h3FFFE
   };

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [15:0]   cpreg = 16'h8000;
   logic          we;
   logic [AW-1:0] waddr;
   logic [33:0]   wdata;
   logic          wbp;
   logic [3:0]    status;
   logic          tb_top = 1'b1;
   logic [15:0]   run_sum;

   int total = 0;
   int bad = 0;
   int wr_n = 0;
   logic [AW-1:0] log_a [16];
   logic [33:0]   log_d [16];
   logic          log_b [16];

   always #5 clk = ~clk;

   tcr_receiver #(.ADDR_W(AW)) u0 (
      .clk(clk), .rst(rst), .cpreg_i(cpreg), .im_we_o(we),
      .im_addr_o(waddr), .im_data_o(wdata), .im_bp_o(wbp), .status_o(status)
   );

   always @(negedge clk) begin
      if (!rst && we) begin
         log_a[wr_n % 16] <= waddr;
         log_d[wr_n % 16] <= wdata;
         log_b[wr_n % 16] <= wbp;
         wr_n <= wr_n + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic put_word(input logic [14:0] p);
      tb_top = ~tb_top;
      cpreg  = {tb_top, p};
      repeat (GAP) @(negedge clk);
   endtask

   task automatic put_half(input logic [18:0] v);
      put_word({7'd0, v[7:0]});
      put_word({4'd0, v[18], v[17], v[16], v[15:8]});
      run_sum = run_sum + v[15:0];
   endtask

   task automatic put_sum(input logic [15:0] s, input logic good);
      put_word({7'd0, s[7:0]});
      put_word({good, 6'd0, s[15:8]});
   endtask

   task automatic start(input logic [AW-1:0] a, input logic [7:0] n);
      run_sum = '0;
      put_word(15'(a));
      put_word({7'd0, n});
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      int base;
      repeat (5) @(negedge clk);
      rst = 1'b0;
      repeat (2) @(negedge clk);
      chk(status == 4'd0, "R11 reset status", 64'(status), 0);
      chk(we == 1'b0, "R11 reset we", 64'(we), 0);

      // R1: bit 15 left at 1 after reset is no new word
      cpreg = 16'h8123;
      repeat (GAP) @(negedge clk);
      chk(status == 4'd0, "R1 no toggle after reset", 64'(status), 0);

      // table-driven transfer, one hunk at 0x3F0
      start(12'h3F0, 8'd1);
      chk(status == 4'd2, "R11 busy after address", 64'(status), 2);
      base = wr_n;
      for (int i = 0; i < 8; i++) begin
         if (i == 0) begin
            // R2: payload garbled 4 cycles after the toggle, no new toggle
            tb_top = ~tb_top;
            cpreg  = {tb_top, 7'd0, VEC[0][7:0]};
            repeat (4) @(negedge clk);
            cpreg  = {tb_top, 15'h7FFF};
            repeat (GAP - 4) @(negedge clk);
            put_word({4'd0, VEC[0][18], VEC[0][17], VEC[0][16], VEC[0][15:8]});
            run_sum = run_sum + VEC[0][15:0];
         end else begin
            put_half(VEC[i]);
         end
      end
      put_sum(run_sum, 1'b1);
      chk(wr_n - base == 4, "R3 four writes per hunk", 64'(wr_n - base), 4);
      for (int k = 0; k < 4; k++) begin
         chk(log_a[(base + k) % 16] == AW'(12'h3F0 + k), "R5 address",
             64'(log_a[(base + k) % 16]), 64'(12'h3F0 + k));
         chk(log_d[(base + k) % 16] == {VEC[2*k][16:0], VEC[2*k+1][16:0]}, "R4 R2 joined data",
             64'(log_d[(base + k) % 16]), 64'({VEC[2*k][16:0], VEC[2*k+1][16:0]}));
         chk(log_b[(base + k) % 16] == (VEC[2*k][18] | VEC[2*k+1][18]), "R4 breakpoint",
             64'(log_b[(base + k) % 16]), 64'(VEC[2*k][18] | VEC[2*k+1][18]));
      end
      chk(status == 4'd1, "R7 acknowledge", 64'(status), 1);

      // R1: payload change with bit 15 held is ignored
      base = wr_n;
      cpreg = {tb_top, 15'h0005};
      repeat (GAP) @(negedge clk);
      chk(status == 4'd1 && wr_n == base, "R1 level ignored", 64'(status), 1);

      // R12 overwrite of a pending left, R6 latency on the right half
      start(12'h040, 8'd1);
      base = wr_n;
      put_half(19'h00111);
      put_half(19'h40222);
      put_word(15'h0033);
      tb_top = ~tb_top;
      cpreg  = {tb_top, 4'd0, 1'b0, 1'b1, 1'b0, 8'h00};
      run_sum = run_sum + 16'h0033;
      repeat (5) @(negedge clk);
      chk(we == 1'b0, "R6 we low in cycle 5", 64'(we), 0);
      @(negedge clk);
      chk(we == 1'b1, "R6 we high in cycle 6", 64'(we), 1);
      @(negedge clk);
      chk(we == 1'b0, "R6 single-cycle pulse", 64'(we), 0);
      repeat (GAP - 7) @(negedge clk);
      chk(log_d[base % 16] == {17'h00222, 17'h00033} && log_b[base % 16] == 1'b1,
          "R12 newer left kept", 64'(log_d[base % 16]), 64'({17'h00222, 17'h00033}));
      put_half(19'h00001); put_half(19'h20002);
      put_half(19'h00003); put_half(19'h20004);
      put_half(19'h00005);
      put_sum(run_sum, 1'b1);
      chk(wr_n - base == 3, "R12 write count", 64'(wr_n - base), 3);
      chk(status == 4'd1, "R7 acknowledge second", 64'(status), 1);

      // R8 orphan right half
      start(12'h100, 8'd1);
      base = wr_n;
      put_half(19'h20077);
      chk(status == 4'd8 && wr_n == base, "R8 orphan right", 64'(status), 8);
      for (int j = 0; j < 6; j++) put_half(19'(j % 2 == 0 ? 19'h00010 : 19'h20020));
      put_half(19'h00001);
      put_sum(run_sum, 1'b1);
      chk(status == 4'd8, "R8 acknowledge suppressed", 64'(status), 8);
      chk(wr_n - base == 3 && log_a[base % 16] == 12'h100, "R8 no address consumed",
          64'(log_a[base % 16]), 64'(12'h100));

      // R10 empty transfer, R9 bad sum and missing good mark
      base = wr_n;
      start(12'h200, 8'd0);
      put_sum(16'h0000, 1'b1);
      chk(status == 4'd1 && wr_n == base, "R10 empty transfer acknowledged", 64'(status), 1);
      start(12'h200, 8'd0);
      put_sum(16'h0001, 1'b1);
      chk(status == 4'd9, "R9 checksum mismatch", 64'(status), 9);
      start(12'h200, 8'd0);
      put_sum(16'h0000, 1'b0);
      chk(status == 4'd9, "R9 good mark missing", 64'(status), 9);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule